// File: doc/BRIEF.md
# Mode Register Command Request Controller

This block turns host register writes into single mode-register commands for a DDR4 memory interface. The host loads a data word and a control word. Setting the trigger bit in the control word starts one request. The controller then presents one command on a valid/ready output toward the memory-side sequencer, and it shows a busy flag until that command has been taken.

One trigger can produce any of three command kinds. Two control fields pick the kind: an MPR-enable bit and a read/write type bit. With MPR-enable clear, a write becomes a mode register set (MRS) command, and the data word is its payload. With MPR-enable set, the request is a multi-purpose register access to one of four 8-bit locations. That access can be a write carrying a byte, or a read. The controller keeps one MPR-mode flag per rank. The flag changes when an MRS to mode register 3 completes, and it is taken from payload bit 2. An MPR access is legal only while its rank's flag is set.

The command output follows valid/ready rules. Once `cmd_valid` rises, it stays high and every command field stays constant until the cycle where `cmd_ready` is also high. The consumer may hold `cmd_ready` low for any number of cycles. The controller accepts no new request during that time.

Top module: `mrcmd_ctrl`

## Requirements
- R1: After reset, `busy`, `cmd_valid`, `err_busy` and `err_req` are 0, `ctrl_rdata` is 0, and no rank is in MPR mode.
- R2: A control write (`host_sel`=1) with bit 31 clear only stages the word. `ctrl_rdata` shows it after the write edge, and `busy` and `cmd_valid` stay 0.
- R3: A legal control write with bit 31 set raises `busy` and `cmd_valid` at the same clock edge that captures the write. `ctrl_rdata[31]` reads 1 until the command handshake.
- R4: Control fields are: bit 0 = type (1 read, 0 write), bit 1 = MPR enable, bit 4 = rank, bits 15:12 = address, bit 31 = trigger. With MPR enable 0 and type 0, the command is kind 0 (MRS), `cmd_addr` is the full 4-bit address and `cmd_data` is the data word.
- R5: With MPR enable 1 and type 0, the command is kind 1 (MPR write), `cmd_addr` is the location and `cmd_data` is data word bits 7:0 with zero upper bits.
- R6: With MPR enable 1 and type 1, the command is kind 2 (MPR read) and `cmd_data` is 0.
- R7: `cmd_rank` equals control bit 4 of the triggering write.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_kind`, `cmd_rank`, `cmd_addr` and `cmd_data` do not change.
- R9: After the edge where `cmd_valid` and `cmd_ready` are both high, `cmd_valid` is 0, `busy` is still 1 and `ctrl_rdata[31]` is 0. At the next edge `busy` falls.
- R10: While `busy` is 1, a trigger write sets the sticky `err_busy` and starts nothing. Control and data writes at that time leave the staged words unchanged.
- R11: A trigger with MPR enable 0 and type 1 is rejected. A trigger for an MPR access to a rank not in MPR mode, or to a location above 3, is also rejected. A rejected trigger sets the sticky `err_req`, leaves `busy` at 0 and stages the word with bit 31 clear. A completed MRS to address 3 sets the rank's MPR-mode flag to payload bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 1 | 1 = control word, 0 = data word |
| host_wdata | input | 32 | Host write value |
| ctrl_rdata | output | 32 | Staged control word; bit 31 shows a pending trigger |
| busy | output | 1 | A request is in progress |
| err_busy | output | 1 | Sticky: trigger arrived while busy |
| err_req | output | 1 | Sticky: illegal request was rejected |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_kind | output | 2 | 0 MRS, 1 MPR write, 2 MPR read |
| cmd_rank | output | 1 | Target rank |
| cmd_addr | output | 4 | Mode register number or MPR location |
| cmd_data | output | 18 | Command payload |

## Verification
Seeded random requests cover all combinations of type, MPR enable, rank and address, with random data and random `cmd_ready` stall lengths. They separate the three command kinds, the payload shaping of each kind, and rank routing. Because MRS writes to address 3 switch MPR mode on and off at random, MPR accesses land both inside and outside MPR mode, which shows whether the per-rank flag is tracked per rank. Directed cases cover reset, staging without a trigger, a zero-cycle stall against a long stall, and writes made while busy. The writes made while busy are checked through the payload of the next command.

// File: rtl/mrcmd_pkg.sv
package mrcmd_pkg;
  localparam int CTRL_W     = 32;
  localparam int F_TYPE     = 0;
  localparam int F_MPR      = 1;
  localparam int F_RANK     = 4;
  localparam int F_ADDR     = 12;
  localparam int ADDR_W     = 4;
  localparam int F_TRIG     = 31;
  localparam int MPR_LOCS   = 4;
  localparam int MPR_BYTE_W = 8;
  localparam logic [ADDR_W-1:0] MR_MPR_CFG = 4'd3;
  localparam int MPR_MODE_BIT = 2;

  typedef enum logic [1:0] {
    CMD_MRS    = 2'd0,
    CMD_MPR_WR = 2'd1,
    CMD_MPR_RD = 2'd2
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DONE  = 2'd2
  } issue_st_e;
endpackage

// File: rtl/mrcmd_decode.sv
module mrcmd_decode
  import mrcmd_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int RANK_W = 1,
  localparam int NRANK = 1 << RANK_W
) (
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [DATA_W-1:0] data_word,
  input  logic [NRANK-1:0]  mpr_mode,
  output logic              legal,
  output cmd_kind_e         kind,
  output logic [RANK_W-1:0] rank,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] payload
);
  logic is_read, is_mpr;

  always_comb begin
    is_read = ctrl_word[F_TYPE];
    is_mpr  = ctrl_word[F_MPR];
    rank    = ctrl_word[F_RANK +: RANK_W];
    addr    = ctrl_word[F_ADDR +: ADDR_W];
    payload = '0;
    kind    = CMD_MRS;
    legal   = 1'b0;
    if (!is_mpr) begin
      kind    = CMD_MRS;
      payload = data_word;
      legal   = !is_read;
    end else begin
      legal = mpr_mode[rank] && (int'(addr) < MPR_LOCS);
      if (is_read) begin
        kind = CMD_MPR_RD;
      end else begin
        kind = CMD_MPR_WR;
        payload[MPR_BYTE_W-1:0] = data_word[MPR_BYTE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mrcmd_regs.sv
module mrcmd_regs
  import mrcmd_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_sel,
  input  logic [CTRL_W-1:0] host_wdata,
  input  logic              busy,
  input  logic              legal,
  input  logic              handshake,
  output logic              accept,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] data_q,
  output logic              err_busy,
  output logic              err_req
);
  logic trig_try, ctrl_wr_ok, data_wr_ok;

  assign trig_try   = host_we && host_sel && host_wdata[F_TRIG];
  assign ctrl_wr_ok = host_we && host_sel && !busy;
  assign data_wr_ok = host_we && !host_sel && !busy;
  assign accept     = trig_try && !busy && legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      data_q   <= '0;
      err_busy <= 1'b0;
      err_req  <= 1'b0;
    end else begin
      if (ctrl_wr_ok) begin
        ctrl_q <= {accept, host_wdata[CTRL_W-2:0]};
      end else if (handshake) begin
        ctrl_q[F_TRIG] <= 1'b0;
      end
      if (data_wr_ok) data_q <= host_wdata[DATA_W-1:0];
      if (trig_try && busy) err_busy <= 1'b1;
      if (trig_try && !busy && !legal) err_req <= 1'b1;
    end
  end
endmodule

// File: rtl/mrcmd_mpr_track.sv
module mrcmd_mpr_track
  import mrcmd_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int RANK_W = 1,
  localparam int NRANK = 1 << RANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              handshake,
  input  cmd_kind_e         kind,
  input  logic [RANK_W-1:0] rank,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] payload,
  output logic [NRANK-1:0]  mpr_mode
);
  logic cfg_hit;
  assign cfg_hit = handshake && (kind == CMD_MRS) && (addr == MR_MPR_CFG);

  for (genvar g = 0; g < NRANK; g++) begin : g_rank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mpr_mode[g] <= 1'b0;
      else if (cfg_hit && (int'(rank) == g)) mpr_mode[g] <= payload[MPR_MODE_BIT];
    end
  end
endmodule

// File: rtl/mrcmd_issue.sv
module mrcmd_issue
  import mrcmd_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int RANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  cmd_kind_e         in_kind,
  input  logic [RANK_W-1:0] in_rank,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_payload,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic              busy,
  output logic              handshake,
  output cmd_kind_e         kind_q,
  output logic [RANK_W-1:0] rank_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] payload_q
);
  issue_st_e st;

  assign cmd_valid = (st == ST_ISSUE);
  assign busy      = (st != ST_IDLE);
  assign handshake = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      kind_q    <= CMD_MRS;
      rank_q    <= '0;
      addr_q    <= '0;
      payload_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          st        <= ST_ISSUE;
          kind_q    <= in_kind;
          rank_q    <= in_rank;
          addr_q    <= in_addr;
          payload_q <= in_payload;
        end
        ST_ISSUE: if (cmd_ready) st <= ST_DONE;
        ST_DONE:  st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mrcmd_ctrl.sv
module mrcmd_ctrl
  import mrcmd_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int RANK_W = 1,
  localparam int NRANK = 1 << RANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_sel,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       ctrl_rdata,
  output logic              busy,
  output logic              err_busy,
  output logic              err_req,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [RANK_W-1:0] cmd_rank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  logic [DATA_W-1:0] data_q;
  logic [NRANK-1:0]  mpr_mode;
  logic              legal, accept, handshake;
  cmd_kind_e         dec_kind, kind_q;
  logic [RANK_W-1:0] dec_rank;
  logic [ADDR_W-1:0] dec_addr;
  logic [DATA_W-1:0] dec_payload;

  mrcmd_decode #(.DATA_W(DATA_W), .RANK_W(RANK_W)) u_decode (
    .ctrl_word(host_wdata), .data_word(data_q), .mpr_mode(mpr_mode),
    .legal(legal), .kind(dec_kind), .rank(dec_rank), .addr(dec_addr),
    .payload(dec_payload)
  );

  mrcmd_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .busy(busy), .legal(legal),
    .handshake(handshake), .accept(accept), .ctrl_q(ctrl_rdata),
    .data_q(data_q), .err_busy(err_busy), .err_req(err_req)
  );

  mrcmd_issue #(.DATA_W(DATA_W), .RANK_W(RANK_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .accept(accept), .in_kind(dec_kind),
    .in_rank(dec_rank), .in_addr(dec_addr), .in_payload(dec_payload),
    .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .busy(busy),
    .handshake(handshake), .kind_q(kind_q), .rank_q(cmd_rank),
    .addr_q(cmd_addr), .payload_q(cmd_data)
  );

  mrcmd_mpr_track #(.DATA_W(DATA_W), .RANK_W(RANK_W)) u_track (
    .clk(clk), .rst_n(rst_n), .handshake(handshake), .kind(kind_q),
    .rank(cmd_rank), .addr(cmd_addr), .payload(cmd_data),
    .mpr_mode(mpr_mode)
  );

  assign cmd_kind = kind_q;
endmodule

// File: rtl/mrcmd_ctrl_chk.sv
module mrcmd_ctrl_chk #(
  parameter int DATA_W = 18,
  parameter int RANK_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic              host_sel,
  input logic [31:0]       host_wdata,
  input logic              busy,
  input logic              err_busy,
  input logic              err_req,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_kind,
  input logic [RANK_W-1:0] cmd_rank,
  input logic [3:0]        cmd_addr,
  input logic [DATA_W-1:0] cmd_data
);
  assert_stage_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel && !host_wdata[31] && !busy) |=> !busy);

  assert_valid_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);

  assert_kind_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_kind != 2'd3));

  assert_mpr_wr_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd1) |-> (cmd_data[DATA_W-1:8] == '0 && cmd_addr < 4'd4));

  assert_mpr_rd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd2) |-> (cmd_data == '0 && cmd_addr < 4'd4));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) && $stable(cmd_rank)
                                   && $stable(cmd_addr) && $stable(cmd_data)));

  assert_busy_tail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && !cmd_valid) ##1 !busy);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_busy |=> err_busy);

  assert_busy_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel && host_wdata[31] && busy) |=> err_busy);

  assert_req_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_req |=> err_req);
endmodule

bind mrcmd_ctrl mrcmd_ctrl_chk #(.DATA_W(DATA_W), .RANK_W(RANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
  .host_wdata(host_wdata), .busy(busy), .err_busy(err_busy),
  .err_req(err_req), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_kind(cmd_kind), .cmd_rank(cmd_rank), .cmd_addr(cmd_addr),
  .cmd_data(cmd_data)
);

// File: tb/mrcmd_ctrl_tb.sv
module mrcmd_ctrl_tb;
  localparam int DW = 18;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 1'b0, host_sel = 1'b0, cmd_ready = 1'b0;
  logic [31:0] host_wdata = '0, ctrl_rdata;
  logic busy, err_busy, err_req, cmd_valid;
  logic [1:0] cmd_kind;
  logic cmd_rank;
  logic [3:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic model_mode [2];
  logic [DW-1:0] model_data;

  always #5 clk = ~clk;

  mrcmd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .ctrl_rdata(ctrl_rdata), .busy(busy),
    .err_busy(err_busy), .err_req(err_req), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_rank(cmd_rank),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input bit trig, input logic [3:0] addr,
                                           input bit rank, input bit mpr, input bit rd);
    return {trig, 15'd0, addr, 7'd0, rank, 2'd0, mpr, rd};
  endfunction

  function automatic bit exp_legal(input logic [31:0] c);
    if (!c[1]) return !c[0];
    return model_mode[c[4]] && (c[15:12] < 4'd4);
  endfunction

  function automatic logic [1:0] exp_kind(input logic [31:0] c);
    if (!c[1]) return 2'd0;
    return c[0] ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [DW-1:0] exp_payload(input logic [31:0] c);
    if (!c[1]) return model_data;
    if (c[0]) return '0;
    return {{(DW-8){1'b0}}, model_data[7:0]};
  endfunction

  task automatic host_wr(input bit sel, input logic [31:0] v);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = v;
    @(posedge clk);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  // Issue a request; stall cycles before ready; optionally poke while busy.
  task automatic run_req(input logic [31:0] c, input int stall, input bit poke);
    bit lg;
    logic [1:0] k;
    logic [DW-1:0] p;
    lg = exp_legal(c);
    k = exp_kind(c);
    p = exp_payload(c);
    host_wr(1'b1, c);
    if (!lg) begin
      chk(!busy && !cmd_valid, "R11 reject no busy", {busy, cmd_valid}, 0);
      chk(err_req, "R11 err_req", err_req, 1);
      chk(ctrl_rdata == {1'b0, c[30:0]}, "R11 staged clear trig", ctrl_rdata, {1'b0, c[30:0]});
      return;
    end
    chk(busy && cmd_valid, "R3 busy+valid same edge", {busy, cmd_valid}, 3);
    chk(ctrl_rdata[31], "R3 trig visible", ctrl_rdata[31], 1);
    chk(cmd_kind == k, "R4 R5 R6 kind", cmd_kind, k);
    chk(cmd_data == p, "R4 R5 R6 payload", cmd_data, p);
    chk(cmd_addr == c[15:12], "R4 R5 addr", cmd_addr, c[15:12]);
    chk(cmd_rank == c[4], "R7 rank", cmd_rank, c[4]);
    if (poke) begin
      host_wr(1'b1, c ^ 32'h0000_3011);
      chk(err_busy && cmd_valid, "R10 err_busy", {err_busy, cmd_valid}, 3);
      chk(ctrl_rdata == {1'b1, c[30:0]}, "R10 ctrl unchanged", ctrl_rdata, {1'b1, c[30:0]});
      host_wr(1'b0, ~32'(model_data));
    end
    for (int i = 0; i < stall; i++) @(negedge clk);
    chk(cmd_valid && cmd_kind == k && cmd_data == p, "R8 held", {cmd_valid, cmd_kind}, {1'b1, k});
    cmd_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_ready = 1'b0;
    chk(!cmd_valid && busy && !ctrl_rdata[31], "R9 after handshake",
        {cmd_valid, busy, ctrl_rdata[31]}, 3'b010);
    @(negedge clk);
    chk(!busy, "R9 busy falls", busy, 0);
    if (!c[1] && c[15:12] == 4'd3) model_mode[c[4]] = model_data[2];
  endtask

  task automatic set_data(input logic [DW-1:0] d);
    host_wr(1'b0, 32'(d));
    model_data = d;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    model_mode[0] = 1'b0; model_mode[1] = 1'b0;
    model_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy && !cmd_valid && !err_busy && !err_req, "R1 reset flags",
        {busy, cmd_valid, err_busy, err_req}, 0);
    chk(ctrl_rdata == 0, "R1 ctrl reset", ctrl_rdata, 0);
    // R1/R11: no rank in MPR mode after reset
    run_req(mk_ctrl(1, 4'd0, 0, 1, 0), 0, 0);
    // R2 stage only
    host_wr(1'b1, mk_ctrl(0, 4'd5, 1, 0, 0));
    chk(ctrl_rdata == mk_ctrl(0, 4'd5, 1, 0, 0), "R2 staged", ctrl_rdata, mk_ctrl(0, 4'd5, 1, 0, 0));
    @(negedge clk);
    chk(!busy && !cmd_valid, "R2 no start", {busy, cmd_valid}, 0);
    // R4 MRS, zero stall
    set_data(18'h2_A5C3);
    run_req(mk_ctrl(1, 4'd6, 0, 0, 0), 0, 0);
    // R11 plain read rejected
    run_req(mk_ctrl(1, 4'd2, 0, 0, 1), 0, 0);
    // enter MPR mode on rank 1
    set_data(18'h0_0004);
    run_req(mk_ctrl(1, 4'd3, 1, 0, 0), 4, 0);
    // R5 MPR write rank 1, with poke while busy (R10)
    set_data(18'h3_FF5A);
    run_req(mk_ctrl(1, 4'd2, 1, 1, 0), 3, 1);
    // R10 data write while busy ignored: next MRS carries the old data word
    run_req(mk_ctrl(1, 4'd1, 0, 0, 0), 0, 0);
    // R6 MPR read rank 1; R11 rank 0 still out of mode; location 4 illegal
    run_req(mk_ctrl(1, 4'd3, 1, 1, 1), 2, 0);
    run_req(mk_ctrl(1, 4'd1, 0, 1, 1), 0, 0);
    run_req(mk_ctrl(1, 4'd4, 1, 1, 0), 0, 0);
    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [31:0] c;
      logic [3:0] a;
      a = ($urandom % 3 == 0) ? 4'd3 : 4'($urandom);
      c = mk_ctrl(1, a, 1'($urandom), 1'($urandom), ($urandom % 4 == 0));
      if ($urandom % 2 == 0) set_data(DW'($urandom));
      run_req(c, $urandom % 4, ($urandom % 8 == 0));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule